// File: doc/BRIEF.md
# Masked-Address GPIO Port Controller

This block is an eight-pin general-purpose I/O port with a 4 KB register window on a simple APB-style slave interface. A write completes in the access phase (`psel`, `penable` and `pwrite` all high) at a rising clock edge. Read data is decoded combinationally from `paddr`. Each pin has its own direction bit. Output pins drive the stored data value, and input pins present logic 1 on `pin_out`. The data register sits behind an aperture of 256 word addresses. Address bits [9:2] act as a per-bit mask on every access, so software can change a single pin without a read-modify-write.

External inputs pass through a two-flop synchronizer. The synchronized levels feed the data register for input pins. They also feed a per-pin event detector that can work on levels, on single edges or on both edges. Detected events collect in a raw status word. Software clears that word by writing ones, and it is gated by an enable mask into one combined interrupt line.

Eight pad-control words are plain storage. The alternate-function word is guarded by two things: a lock that only a fixed 32-bit key opens, and a commit word that sets which alternate-function bits may change. Twelve read-only identification bytes sit at the top of the window.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset:
  - `pin_out` is 0xFF and `irq` is 0.
  - The lock word (0x520) reads 1 and the commit word (0x524) reads 0xFF.
  - Direction (0x400) and data read 0.
- R2: A read at an offset in 0x000–0x3FC returns the data register ANDed with offset bits [9:2].
- R3: A write in the aperture changes only those data bits that are set in offset bits [9:2] and whose direction bit (0x400, 1 = output) is 1.
- R4: Each bit of `pin_out` equals the data bit when the pin is an output and is 1 when the pin is an input.
- R5: For a pin whose direction bit is 0, the data bit takes the `pin_in` level after a two-flop synchronizer.
- R6: Writing 0x0ACCE551 to 0x520 unlocks the port, and writing any other value locks it. 0x520 reads 1 when locked and 0 when unlocked.
- R7: The commit word (0x524) can be written only while unlocked. A write to the alternate-function word (0x420) changes only the bits whose commit bit is 1.
- R8: With sense (0x404) bit 0 and both-edges (0x408) bit 0, a polarity (0x40C) bit of 1 sets raw status (0x414) on a rising edge, and a polarity bit of 0 sets it on a falling edge.
- R9: With sense bit 0 and both-edges bit 1, either edge sets the raw status bit.
- R10: With sense bit 1, the raw status bit is set on every cycle in which the synchronized input equals the polarity bit. The bit therefore sets again right after a clear. Output pins never raise events.
- R11: Writing ones to 0x41C clears those raw status bits. Masked status (0x418) reads raw AND enable (0x410). `irq` is the OR of the masked status bits.
- R12: Offsets 0xFD0–0xFFC read the bytes 00 00 00 00 61 10 04 00 0D F0 05 B1, one per word in ascending order. Unmapped offsets read 0.
- R13: The eight pad-control words at 0x500–0x51C and the interrupt configuration words read back the last 8-bit value written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset in the register window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational on `paddr` |
| pin_in | input | 8 | External pin levels, asynchronous |
| pin_out | output | 8 | Pin drive values |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the port at its default eight pins with two synchronizer stages. At this size all 256 aperture masks can be swept for both writes and reads under several direction patterns, so every mask and direction combination is compared against an arithmetic model. The eight-pin width also lets each event-detection mode be set up with a mix of per-pin polarities and both-edge bits in one step. The expected raw status word is then computed from the old and new pin patterns.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned WORD_W = 10;

  // Word indices (byte offset >> 2)
  localparam logic [WORD_W-1:0] W_DIR    = 10'h100;
  localparam logic [WORD_W-1:0] W_SENSE  = 10'h101;
  localparam logic [WORD_W-1:0] W_BOTH   = 10'h102;
  localparam logic [WORD_W-1:0] W_POL    = 10'h103;
  localparam logic [WORD_W-1:0] W_ENA    = 10'h104;
  localparam logic [WORD_W-1:0] W_RAW    = 10'h105;
  localparam logic [WORD_W-1:0] W_MSK    = 10'h106;
  localparam logic [WORD_W-1:0] W_CLR    = 10'h107;
  localparam logic [WORD_W-1:0] W_ALT    = 10'h108;
  localparam logic [WORD_W-1:0] W_PAD0   = 10'h140;
  localparam logic [WORD_W-1:0] W_LOCK   = 10'h148;
  localparam logic [WORD_W-1:0] W_COMMIT = 10'h149;
  localparam logic [WORD_W-1:0] W_IDENT  = 10'h3F4;

  localparam int unsigned PAD_WORDS = 8;
  localparam logic [31:0] UNLOCK_KEY = 32'h0ACC_E551;

  typedef enum logic [2:0] {
    PAD_DRV_LO, PAD_DRV_MID, PAD_DRV_HI, PAD_OPEN_DRAIN,
    PAD_PULL_UP, PAD_PULL_DN, PAD_SLEW, PAD_DIG_EN
  } pad_sel_e;

  function automatic logic [7:0] ident_byte(input logic [3:0] idx);
    case (idx)
      4'd4:    ident_byte = 8'h61;
      4'd5:    ident_byte = 8'h10;
      4'd6:    ident_byte = 8'h04;
      4'd8:    ident_byte = 8'h0D;
      4'd9:    ident_byte = 8'hF0;
      4'd10:   ident_byte = 8'h05;
      4'd11:   ident_byte = 8'hB1;
      default: ident_byte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = async_in;
    end else begin : g_next
      assign stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d;
    end
  end

  assign sync_out = stg_q[STAGES-1];

endmodule

// File: rtl/gpio_event_unit.sv
module gpio_event_unit #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level,
  input  logic [WIDTH-1:0] is_output,
  input  logic [WIDTH-1:0] sense_lvl,
  input  logic [WIDTH-1:0] both_edges,
  input  logic [WIDTH-1:0] polarity,
  input  logic [WIDTH-1:0] clear_bits,
  output logic [WIDTH-1:0] raw_status
);

  logic [WIDTH-1:0] prev_q, raw_q, raw_d;
  logic [WIDTH-1:0] rise, fall, edge_hit, lvl_hit, event_hit;

  always_comb begin
    rise      = level & ~prev_q;
    fall      = ~level & prev_q;
    edge_hit  = (both_edges & (rise | fall)) |
                (~both_edges & ((polarity & rise) | (~polarity & fall)));
    lvl_hit   = ~(level ^ polarity);
    event_hit = ~is_output & ((sense_lvl & lvl_hit) | (~sense_lvl & edge_hit));
    raw_d     = (raw_q & ~clear_bits) | event_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      raw_q  <= '0;
    end else begin
      prev_q <= level;
      raw_q  <= raw_d;
    end
  end

  assign raw_status = raw_q;

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int unsigned N_PINS      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [11:0]       paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic              irq
);

  localparam int unsigned MSB = N_PINS - 1;

  logic [WORD_W-1:0] word;
  logic              wr_en, in_aperture;
  logic [MSB:0]      amask, wdat, sync_in;
  logic              unused_addr_lsb;

  assign word            = paddr[11:2];
  assign wr_en           = psel & penable & pwrite;
  assign amask           = paddr[N_PINS+1:2];
  assign in_aperture     = (paddr[11:10] == 2'b00);
  assign wdat            = pwdata[MSB:0];
  assign unused_addr_lsb = ^paddr[1:0];

  logic [MSB:0] data_q, dir_q, sense_q, both_q, pol_q, ena_q, alt_q, cr_q;
  logic [MSB:0] data_d, dir_d, sense_d, both_d, pol_d, ena_d, alt_d, cr_d;
  logic [MSB:0] clr_bits, raw_q;
  logic         locked_q, locked_d;
  logic [MSB:0] pad_q [PAD_WORDS];

  gpio_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(sync_in)
  );

  gpio_event_unit #(.WIDTH(N_PINS)) u_events (
    .clk(clk), .rst_n(rst_n), .level(sync_in), .is_output(dir_q),
    .sense_lvl(sense_q), .both_edges(both_q), .polarity(pol_q),
    .clear_bits(clr_bits), .raw_status(raw_q)
  );

  // Next-state logic
  always_comb begin
    data_d   = (data_q & dir_q) | (sync_in & ~dir_q);
    dir_d    = dir_q;
    sense_d  = sense_q;
    both_d   = both_q;
    pol_d    = pol_q;
    ena_d    = ena_q;
    alt_d    = alt_q;
    cr_d     = cr_q;
    locked_d = locked_q;
    clr_bits = '0;
    if (wr_en && in_aperture) begin
      data_d = (data_d & ~(amask & dir_q)) | (wdat & amask & dir_q);
    end else if (wr_en) begin
      case (word)
        W_DIR:    dir_d    = wdat;
        W_SENSE:  sense_d  = wdat;
        W_BOTH:   both_d   = wdat;
        W_POL:    pol_d    = wdat;
        W_ENA:    ena_d    = wdat;
        W_CLR:    clr_bits = wdat;
        W_ALT:    alt_d    = (alt_q & ~cr_q) | (wdat & cr_q);
        W_LOCK:   locked_d = (pwdata != UNLOCK_KEY);
        W_COMMIT: if (!locked_q) cr_d = wdat;
        default:  ;
      endcase
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      dir_q    <= '0;
      sense_q  <= '0;
      both_q   <= '0;
      pol_q    <= '0;
      ena_q    <= '0;
      alt_q    <= '0;
      cr_q     <= '1;
      locked_q <= 1'b1;
    end else begin
      data_q   <= data_d;
      dir_q    <= dir_d;
      sense_q  <= sense_d;
      both_q   <= both_d;
      pol_q    <= pol_d;
      ena_q    <= ena_d;
      alt_q    <= alt_d;
      cr_q     <= cr_d;
      locked_q <= locked_d;
    end
  end

  // Pad-control storage words, one per select value
  for (genvar p = 0; p < PAD_WORDS; p++) begin : g_pad
    logic pad_we;
    assign pad_we = wr_en && !in_aperture && (word == W_PAD0 + WORD_W'(p));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pad_q[p] <= '0;
      else if (pad_we) pad_q[p] <= wdat;
    end
  end

  // Read decode
  always_comb begin
    prdata = '0;
    if (in_aperture) begin
      prdata[MSB:0] = data_q & amask;
    end else if (word >= W_IDENT) begin
      prdata[7:0] = ident_byte(word[3:0] - 4'd4);
    end else if (word[WORD_W-1:3] == W_PAD0[WORD_W-1:3]) begin
      prdata[MSB:0] = pad_q[word[2:0]];
    end else begin
      case (word)
        W_DIR:    prdata[MSB:0] = dir_q;
        W_SENSE:  prdata[MSB:0] = sense_q;
        W_BOTH:   prdata[MSB:0] = both_q;
        W_POL:    prdata[MSB:0] = pol_q;
        W_ENA:    prdata[MSB:0] = ena_q;
        W_RAW:    prdata[MSB:0] = raw_q;
        W_MSK:    prdata[MSB:0] = raw_q & ena_q;
        W_ALT:    prdata[MSB:0] = alt_q;
        W_LOCK:   prdata[0]     = locked_q;
        W_COMMIT: prdata[MSB:0] = cr_q;
        default:  ;
      endcase
    end
  end

  assign pin_out = (data_q & dir_q) | ~dir_q;
  assign irq     = |(raw_q & ena_q);

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int unsigned N_PINS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [11:0]       paddr,
  input logic [31:0]       pwdata,
  input logic [N_PINS-1:0] pin_out,
  input logic              irq,
  input logic [N_PINS-1:0] dir_q,
  input logic [N_PINS-1:0] cr_q,
  input logic [N_PINS-1:0] alt_q,
  input logic [N_PINS-1:0] raw_q,
  input logic [N_PINS-1:0] ena_q,
  input logic              locked_q
);

  logic lock_wr;
  assign lock_wr = psel && penable && pwrite && (paddr == 12'h520);

  a_r4_inputs_float: assert property (@(posedge clk) disable iff (!rst_n)
    ((~dir_q & ~pin_out) == '0));

  a_r6_key_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_wr && pwdata == UNLOCK_KEY) |=> !locked_q);

  a_r6_other_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_wr && pwdata != UNLOCK_KEY) |=> locked_q);

  a_r7_commit_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(cr_q));

  a_r7_alt_guarded: assert property (@(posedge clk) disable iff (!rst_n)
    ((alt_q ^ $past(alt_q)) & ~$past(cr_q)) == '0);

  a_r11_irq_needs_raw: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (raw_q != '0));

  a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ena_q == '0) |-> !irq);

endmodule

bind gpio_port_ctrl gpio_port_chk #(.N_PINS(N_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .pin_out(pin_out), .irq(irq),
  .dir_q(dir_q), .cr_q(cr_q), .alt_q(alt_q), .raw_q(raw_q), .ena_q(ena_q),
  .locked_q(locked_q)
);

// File: tb/test_gpio_port_ctrl.sv
`timescale 1ns/1ps
module test_gpio_port_ctrl;

  logic        clk = 1'b0;
  logic        rst_n, psel, penable, pwrite;
  logic [11:0] paddr;
  logic [31:0] pwdata, prdata;
  logic [7:0]  pin_in, pin_out;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  gpio_port_ctrl i_gpio_port_ctrl (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pin_in(pin_in), .pin_out(pin_out), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] edge_model(input logic [7:0] old_v, input logic [7:0] new_v,
                                            input logic [7:0] both, input logic [7:0] pol);
    logic [7:0] r, f;
    r = new_v & ~old_v;
    f = old_v & ~new_v;
    return (both & (r | f)) | (~both & ((pol & r) | (~pol & f)));
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d expected <150000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] id_exp [12] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h61, 8'h10,
                                8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    logic [7:0] dirs [3] = '{8'hFF, 8'hF0, 8'h5A};
    logic [7:0] outm, full, raw, pol, both;

    rst_n = 0; psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0; pin_in = '0;
    idle(4);
    rst_n = 1;
    idle(2);

    // R1 reset state
    check("R1 pin_out", {24'h0, pin_out}, 32'hFF);
    check("R1 irq", {31'h0, irq}, 32'h0);
    rd_chk("R1 lock", 12'h520, 32'h1);
    rd_chk("R1 commit", 12'h524, 32'hFF);
    rd_chk("R1 dir", 12'h400, 32'h0);
    rd_chk("R1 data", 12'h3FC, 32'h0);

    // R13 storage words
    for (int i = 0; i < 8; i++) wr(12'h500 + 12'(i * 4), 32'((i * 37 + 5) & 8'hFF));
    for (int i = 0; i < 8; i++) rd_chk("R13 pad", 12'h500 + 12'(i * 4), 32'((i * 37 + 5) & 8'hFF));
    wr(12'h404, 32'h0); wr(12'h408, 32'h96); wr(12'h40C, 32'h3C); wr(12'h410, 32'hC3);
    rd_chk("R13 both", 12'h408, 32'h96);
    rd_chk("R13 pol", 12'h40C, 32'h3C);
    rd_chk("R13 ena", 12'h410, 32'hC3);
    wr(12'h408, 32'h0); wr(12'h40C, 32'h0); wr(12'h410, 32'h0);

    // R2/R3/R4 aperture sweeps
    pin_in = 8'h0F;
    idle(5);
    for (int k = 0; k < 3; k++) begin
      wr(12'h400, {24'h0, dirs[k]});
      wr(12'h3FC, 32'h0);
      outm = 8'h00;
      for (int m = 0; m < 256; m++) begin
        logic [7:0] v;
        v = 8'((m * 7 + 3) & 8'hFF);
        wr(12'(m << 2), {24'h0, v});
        outm = (outm & ~(8'(m) & dirs[k])) | (v & 8'(m) & dirs[k]);
        check("R3/R4 pin_out", {24'h0, pin_out}, {24'h0, (outm & dirs[k]) | ~dirs[k]});
      end
      full = (outm & dirs[k]) | (pin_in & ~dirs[k]);
      for (int m = 0; m < 256; m++)
        rd_chk("R2 masked read", 12'(m << 2), {24'h0, full & 8'(m)});
    end

    // R5 input synchronization
    wr(12'h400, 32'h0);
    pin_in = 8'hA5;
    idle(4);
    rd_chk("R5 input capture", 12'h3FC, 32'hA5);
    check("R5 inputs float", {24'h0, pin_out}, 32'hFF);
    pin_in = 8'h3C;
    idle(4);
    rd_chk("R5 input follow", 12'h3FC, 32'h3C);

    // R6 lock
    rd_chk("R6 locked", 12'h520, 32'h1);
    wr(12'h520, 32'h0ACCE551);
    rd_chk("R6 unlocked", 12'h520, 32'h0);
    wr(12'h520, 32'h0ACCE550);
    rd_chk("R6 relock", 12'h520, 32'h1);
    wr(12'h520, 32'h0ACCE551);
    rd_chk("R6 unlock again", 12'h520, 32'h0);

    // R7 commit and alternate function
    wr(12'h524, 32'h0F);
    rd_chk("R7 commit unlocked", 12'h524, 32'h0F);
    wr(12'h520, 32'h0);
    wr(12'h524, 32'hFF);
    rd_chk("R7 commit locked", 12'h524, 32'h0F);
    wr(12'h420, 32'hFF);
    rd_chk("R7 alt all", 12'h420, 32'h0F);
    wr(12'h420, 32'hA0);
    rd_chk("R7 alt masked", 12'h420, 32'h00);
    wr(12'h420, 32'h5A);
    rd_chk("R7 alt low", 12'h420, 32'h0A);

    // R8 single edges
    pin_in = 8'h00; idle(5);
    both = 8'h00; pol = 8'hF0;
    wr(12'h404, 32'h0); wr(12'h408, 32'h0); wr(12'h40C, {24'h0, pol}); wr(12'h410, 32'hFF);
    wr(12'h41C, 32'hFF);
    rd_chk("R8 cleared", 12'h414, 32'h0);
    pin_in = 8'hFF; idle(5);
    rd_chk("R8 rising", 12'h414, {24'h0, edge_model(8'h00, 8'hFF, both, pol)});
    check("R8 irq", {31'h0, irq}, 32'h1);
    wr(12'h41C, 32'hFF);
    pin_in = 8'h00; idle(5);
    rd_chk("R8 falling", 12'h414, {24'h0, edge_model(8'hFF, 8'h00, both, pol)});
    wr(12'h41C, 32'hFF);

    // R9 both edges
    both = 8'h33;
    wr(12'h408, {24'h0, both});
    pin_in = 8'hFF; idle(5);
    rd_chk("R9 up", 12'h414, {24'h0, edge_model(8'h00, 8'hFF, both, pol)});
    wr(12'h41C, 32'hFF);
    pin_in = 8'h00; idle(5);
    raw = edge_model(8'hFF, 8'h00, both, pol);
    rd_chk("R9 down", 12'h414, {24'h0, raw});

    // R11 mask, clear, irq
    wr(12'h410, 32'h0F);
    rd_chk("R11 masked", 12'h418, {24'h0, raw & 8'h0F});
    check("R11 irq", {31'h0, irq}, {31'h0, |(raw & 8'h0F)});
    wr(12'h41C, 32'h05);
    raw = raw & ~8'h05;
    rd_chk("R11 partial clear", 12'h414, {24'h0, raw});
    wr(12'h410, 32'h0);
    check("R11 irq off", {31'h0, irq}, 32'h0);
    wr(12'h41C, 32'hFF);
    rd_chk("R11 all clear", 12'h414, 32'h0);

    // R10 level detection
    wr(12'h408, 32'h0);
    wr(12'h40C, 32'h0F);
    wr(12'h404, 32'hFF);
    pin_in = 8'h0C; idle(5);
    wr(12'h41C, 32'hFF);
    rd_chk("R10 level resets", 12'h414, {24'h0, ~(8'h0C ^ 8'h0F)});
    wr(12'h400, 32'hF0);
    wr(12'h41C, 32'hFF);
    rd_chk("R10 inputs only", 12'h414, {24'h0, ~(8'h0C ^ 8'h0F) & 8'h0F});
    wr(12'h404, 32'h0);

    // R12 identification and unmapped
    for (int i = 0; i < 12; i++) rd_chk("R12 ident", 12'hFD0 + 12'(i * 4), {24'h0, id_exp[i]});
    rd_chk("R12 unmapped 428", 12'h428, 32'h0);
    rd_chk("R12 unmapped 800", 12'h800, 32'h0);
    rd_chk("R12 unmapped FCC", 12'hFCC, 32'h0);
    rd_chk("R12 clear word", 12'h41C, 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule